// File: doc/BRIEF.md
# Dual-Channel Coded-Ratio Clock Divider

This block takes one high-rate oscillator clock and derives two output clocks from it, one per channel. Each channel has a 3-bit select code that picks its division ratio from a fixed, irregular set that includes odd values. Each output is delivered as a true/complement pair. Every channel has its own output enable. One master reset is shared by both channels.

Even ratios give an exact 50% duty cycle. Odd ratios above one use the falling edge of the clock, so the high phase lasts half the period to half-cycle resolution. A ratio of one passes the clock straight through. A new select code only takes effect at the boundary of the current output period, so a ratio change never produces a shortened pulse. The reset state and the disabled state both park the pair with the true side low and the complement side high.

Top module: `dual_ratio_divider`

## Requirements
- R1: A select code c picks the ratio R as follows: 0 picks 1, 1 picks 2, 2 picks 3, 3 picks 4, 4 picks 5, 5 picks 6, 6 picks 8 and 7 picks 16. Code 3 (divide-by-4) is the usual power-up setting.
- R2: With the select code held steady, each true output repeats with a period of exactly R clock cycles.
- R3: For even R, the true output is high for exactly R/2 clock cycles in each period.
- R4: For odd R above one, the true output is high for R/2 clock cycles in each period, counted in half cycles. For example, 1.5 of 3 and 2.5 of 5.
- R5: For R = 1, the true output follows the input clock while the channel is enabled and out of reset.
- R6: The two channels divide independently, and each uses its own select code.
- R7: While a channel's enable is low, its true output is low and its complement output is high. The other channel is unaffected.
- R8: While master reset is high, both true outputs are low and both complement outputs are high. The dividers restart when reset falls. The select codes are kept, and the first full period begins at the first rising clock edge after release.
- R9: A select code change takes effect only at the end of the current output period. The period that is in progress finishes with the old ratio.
- R10: Outside reset and disable, each complement output is always the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | High-rate source clock |
| mr | input | 1 | Master reset, active high, shared by both channels |
| sel_a | input | 3 | Ratio select code, channel A |
| en_a | input | 1 | Output enable, channel A |
| sel_b | input | 3 | Ratio select code, channel B |
| en_b | input | 1 | Output enable, channel B |
| fout_a | output | 1 | Channel A true output |
| fout_a_n | output | 1 | Channel A complement output |
| fout_b | output | 1 | Channel B true output |
| fout_b_n | output | 1 | Channel B complement output |

## Verification
A select code change and the end of an output period can land on the same clock edge. The bench provokes this in two ways: it writes a new code mid-period, and it writes one in the very last half cycle before the boundary edge. In both cases the bench counts the half cycles between successive rising edges of the true output. The period in progress must still have the old length, and the period after it must have the new one. Both outputs are sampled once per half cycle, so the same samples also measure duty cycle and check the complement relation.

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider #(
  parameter int MAX_RATIO = 16
) (
  input  logic       clk_vco,
  input  logic       mr,
  input  logic [2:0] sel_a,
  input  logic       en_a,
  input  logic [2:0] sel_b,
  input  logic       en_b,
  output logic       fout_a,
  output logic       fout_a_n,
  output logic       fout_b,
  output logic       fout_b_n
);
  localparam int CNT_W = $clog2(MAX_RATIO);
  localparam int RW    = CNT_W + 1;

  logic [1:0][2:0]       sel_v;
  logic [1:0][2:0]       code_q;
  logic [1:0][CNT_W-1:0] cnt_q;
  logic [1:0]            en_v;
  logic [1:0]            at_end;
  logic [1:0]            tru;

  assign sel_v = {sel_b, sel_a};
  assign en_v  = {en_b, en_a};

  function automatic logic [RW-1:0] ratio_of(input logic [2:0] c);
    case (c)
      3'd0:    return RW'(1);
      3'd1:    return RW'(2);
      3'd2:    return RW'(3);
      3'd3:    return RW'(4);
      3'd4:    return RW'(5);
      3'd5:    return RW'(6);
      3'd6:    return RW'(8);
      default: return RW'(16);
    endcase
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [2:0]       code_r;
    logic [CNT_W-1:0] cnt_r;
    logic [CNT_W-1:0] cnt_inc;
    logic [RW-1:0]    r_cur;
    logic [RW-1:0]    r_nxt;
    logic             hi_p;
    logic             hi_n;
    logic             raw;

    assign r_cur     = ratio_of(code_r);
    assign r_nxt     = ratio_of(sel_v[g]);
    assign cnt_inc   = cnt_r + CNT_W'(1);
    assign at_end[g] = {1'b0, cnt_r} == (r_cur - RW'(1));
    assign code_q[g] = code_r;
    assign cnt_q[g]  = cnt_r;

    always_ff @(posedge clk_vco) begin
      if (mr) begin
        code_r <= sel_v[g];
        cnt_r  <= CNT_W'(r_nxt - RW'(1));
        hi_p   <= 1'b0;
      end else if (at_end[g]) begin
        code_r <= sel_v[g];
        cnt_r  <= '0;
        hi_p   <= (r_nxt >> 1) != '0;
      end else begin
        cnt_r  <= cnt_inc;
        hi_p   <= {1'b0, cnt_inc} < (r_cur >> 1);
      end
    end

    always_ff @(negedge clk_vco) begin
      if (mr) hi_n <= 1'b0;
      else    hi_n <= hi_p;
    end

    assign raw    = (r_cur == RW'(1)) ? clk_vco : (hi_p | (r_cur[0] & hi_n));
    assign tru[g] = raw & en_v[g] & ~mr;
  end

  assign fout_a   = tru[0];
  assign fout_a_n = ~tru[0];
  assign fout_b   = tru[1];
  assign fout_b_n = ~tru[1];
endmodule

// File: rtl/dual_ratio_divider_chk.sv
module dual_ratio_divider_chk (
  input logic            clk_vco,
  input logic            mr,
  input logic            en_a,
  input logic            en_b,
  input logic            fout_a,
  input logic            fout_a_n,
  input logic            fout_b,
  input logic            fout_b_n,
  input logic [1:0]      at_end,
  input logic [1:0][2:0] code_q
);
  assert_reset_park_R8: assert property (@(negedge clk_vco)
    mr |-> (!fout_a && fout_a_n && !fout_b && fout_b_n));

  assert_disable_park_a_R7: assert property (@(negedge clk_vco) disable iff (mr)
    !en_a |-> (!fout_a && fout_a_n));

  assert_disable_park_b_R7: assert property (@(negedge clk_vco) disable iff (mr)
    !en_b |-> (!fout_b && fout_b_n));

  assert_complement_R10: assert property (@(negedge clk_vco) disable iff (mr)
    (fout_a_n == !fout_a) && (fout_b_n == !fout_b));

  assert_code_at_end_a_R9: assert property (@(posedge clk_vco) disable iff (mr)
    !$stable(code_q[0]) |-> $past(at_end[0]));

  assert_code_at_end_b_R9: assert property (@(posedge clk_vco) disable iff (mr)
    !$stable(code_q[1]) |-> $past(at_end[1]));
endmodule

bind dual_ratio_divider dual_ratio_divider_chk u_chk (
  .clk_vco (clk_vco),
  .mr      (mr),
  .en_a    (en_a),
  .en_b    (en_b),
  .fout_a  (fout_a),
  .fout_a_n(fout_a_n),
  .fout_b  (fout_b),
  .fout_b_n(fout_b_n),
  .at_end  (at_end),
  .code_q  (code_q)
);

// File: tb/test_dual_ratio_divider.sv
module test_dual_ratio_divider;
  logic       clk_vco = 1'b0;
  logic       mr = 1'b1;
  logic [2:0] sel_a = 3'd3;
  logic [2:0] sel_b = 3'd3;
  logic       en_a = 1'b1;
  logic       en_b = 1'b1;
  logic       fout_a, fout_a_n, fout_b, fout_b_n;

  int checks = 0;
  int errors = 0;
  int comp_bad = 0;

  always #2 clk_vco = ~clk_vco;

  dual_ratio_divider i_dual_ratio_divider (
    .clk_vco, .mr, .sel_a, .en_a, .sel_b, .en_b,
    .fout_a, .fout_a_n, .fout_b, .fout_b_n
  );

  function automatic int exp_ratio(input int c);
    case (c)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 5;  5: return 6;  6: return 8;  default: return 16;
    endcase
  endfunction

  function automatic logic get_p(input int ch);
    return ch == 0 ? fout_a : fout_b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic half();
    @(clk_vco);
    #1;
    if (!mr && (fout_a_n == fout_a || fout_b_n == fout_b)) comp_bad++;
  endtask

  task automatic set_sel(input int ch, input int c);
    if (ch == 0) sel_a = 3'(c); else sel_b = 3'(c);
  endtask

  task automatic wait_rise(input int ch, output bit ok);
    logic prev = get_p(ch);
    ok = 0;
    for (int i = 0; i < 200 && !ok; i++) begin
      half();
      if (!prev && get_p(ch)) ok = 1;
      prev = get_p(ch);
    end
  endtask

  task automatic count_period(input int ch, input int change_at, input int new_code,
                              output int per, output int hi);
    logic prev = 1'b0;
    logic cur = get_p(ch);
    per = 0; hi = 0;
    do begin
      hi += int'(cur);
      per++;
      if (per == change_at) set_sel(ch, new_code);
      prev = cur;
      half();
      cur = get_p(ch);
    end while (!(!prev && cur) && per < 200);
  endtask

  task automatic measure(input int ch, output int per, output int hi);
    bit ok;
    wait_rise(ch, ok);
    if (!ok) begin per = 0; hi = 0; end
    else count_period(ch, -1, 0, per, hi);
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      half();
      if (fout_a || !fout_a_n || fout_b || !fout_b_n) bad++;
    end
    chk("R8 reset park", bad, 0);
    mr = 1'b0;
  endtask

  task automatic t_ratios();
    int per, hi;
    bit ok;
    for (int c = 0; c < 8; c++) begin
      sel_a = 3'(c);
      sel_b = 3'(7 - c);
      for (int k = 0; k < 3; k++) wait_rise(0, ok);
      measure(0, per, hi);
      chk($sformatf("R1 R2 A period halves code %0d", c), per, 2 * exp_ratio(c));
      chk($sformatf("R3 R4 R5 A high halves code %0d", c), hi, exp_ratio(c));
      for (int k = 0; k < 2; k++) wait_rise(1, ok);
      measure(1, per, hi);
      chk($sformatf("R6 B period halves code %0d", 7 - c), per, 2 * exp_ratio(7 - c));
      chk($sformatf("R6 B high halves code %0d", 7 - c), hi, exp_ratio(7 - c));
    end
  endtask

  task automatic t_enable();
    int bad = 0;
    int per, hi;
    bit ok;
    sel_a = 3'd2; sel_b = 3'd4;
    for (int k = 0; k < 3; k++) wait_rise(1, ok);
    en_a = 1'b0;
    for (int i = 0; i < 20; i++) begin
      half();
      if (fout_a || !fout_a_n) bad++;
    end
    chk("R7 disabled A parked", bad, 0);
    measure(1, per, hi);
    chk("R7 B unaffected period", per, 10);
    en_a = 1'b1;
    measure(0, per, hi);
    chk("R7 A resumes period", per, 6);
  endtask

  task automatic t_change();
    int per, hi;
    bit ok;
    sel_a = 3'd7;
    for (int k = 0; k < 3; k++) wait_rise(0, ok);
    count_period(0, 5, 1, per, hi);
    chk("R9 mid-period change keeps old period", per, 32);
    count_period(0, -1, 0, per, hi);
    chk("R9 new ratio after boundary", per, 4);
    sel_a = 3'd4;
    for (int k = 0; k < 3; k++) wait_rise(0, ok);
    count_period(0, 10, 2, per, hi);
    chk("R9 change in last half keeps old period", per, 10);
    count_period(0, -1, 0, per, hi);
    chk("R9 new ratio after late change", per, 6);
    chk("R9 new ratio high halves", hi, 3);
  endtask

  task automatic t_mreset();
    int bad = 0;
    int per, hi;
    sel_a = 3'd5; sel_b = 3'd6;
    half(); half(); half();
    mr = 1'b1;
    #0;
    if (fout_a || !fout_a_n || fout_b || !fout_b_n) bad++;
    for (int i = 0; i < 10; i++) begin
      half();
      if (fout_a || !fout_a_n || fout_b || !fout_b_n) bad++;
    end
    chk("R8 mid-run reset park", bad, 0);
    while (clk_vco) half();
    mr = 1'b0;
    per = 0;
    while (!fout_a && per < 50) begin half(); per++; end
    chk("R8 first period starts at first rising edge", per, 1);
    count_period(0, -1, 0, per, hi);
    chk("R8 A ratio kept after reset", per, 12);
    measure(1, per, hi);
    chk("R8 B ratio kept after reset", per, 16);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ratios();
    t_enable();
    t_change();
    t_mreset();
    chk("R10 complement mismatches", comp_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule